// File: doc/BRIEF.md
# Debug Capability Control and Status Register

This block holds the 32-bit control and status word of a USB debug capability. Software reaches it through a plain whole-word read/write port. The protocol logic around it supplies several inputs: the configured-state indication, the device address assigned at enumeration, a fixed maximum burst value, a port-reset pulse, halt-clear requests for each ring, and the link status change indication. The block drives the capability enable, the doorbell enable, a stall request per ring, a one-cycle release/terminate pulse and a port status change event request.

Several rules are tied together in the register. The run flag follows the configured state only while the capability is enabled. A port reset drops the run flag and keeps it low until the configured state is seen low and then high again. Whenever the run flag falls, a sticky run-change flag is set, and while that flag is set the doorbell is shut. The two set-only halt bits have an effect only while the capability is running.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After reset every writable and hardware-set bit reads 0: bit 31, bit 4, bits 3:2, bit 1 and bit 0. All six outputs are low.
- R2: Bit 31 is the capability enable. A write stores it, it reads back, and it drives cap_en_o from the cycle after the write.
- R3: A write that changes bit 31 from 1 to 0 produces release_o high for exactly one cycle, the cycle after the write. Writing 0 while it is already 0 produces no pulse.
- R4: Bits 30:24 show dev_addr_i and bits 23:16 show max_burst_i, both live. Writes to these bits have no effect. Bits 15:5 always read 0.
- R5: Bit 0, the run flag, becomes 1 one cycle after cfg_state_i is seen high while the enable is 1. It becomes 0 one cycle after cfg_state_i is seen low. It also becomes 0 in the cycle after a write that clears bit 31.
- R6: A 0-to-1 edge on port_reset_i forces the run flag to 0 on the next cycle. The flag stays 0 until cfg_state_i has been seen low and then high again.
- R7: Bit 4 is set in the same cycle that the run flag goes from 1 to 0. Writing 1 to bit 4 clears it. When a clear and a set happen in the same cycle, the set wins. doorbell_en_o is high only when bit 31 is 1 and bit 4 is 0.
- R8: Bit 3 (IN halt) and bit 2 (OUT halt) are set by writing 1 while the run flag is 1. Writing 0 to them has no effect. While the run flag is 0 they read 0 and writes to them are ignored.
- R9: halt_clr_in_i clears bit 3 and halt_clr_out_i clears bit 2 on the next cycle. A clear request wins over a write that sets the same bit in the same cycle.
- R10: Both halt bits are forced to 0 when the run flag falls, and they stay 0 after the run flag rises again.
- R11: stall_in_o equals bit 3 and stall_out_o equals bit 2.
- R12: Bit 1 is a read/write event enable. While it is 1, a 0-to-1 edge on link_chg_i raises psc_evt_o for one cycle, the cycle after the edge. While it is 0, no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Whole-word write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register value (combinational read) |
| cfg_state_i | input | 1 | Debug device is in the configured state |
| dev_addr_i | input | 7 | Device address assigned at enumeration |
| max_burst_i | input | 8 | Fixed maximum burst size |
| port_reset_i | input | 1 | Port reset indication (edge-sensitive) |
| halt_clr_in_i | input | 1 | Halt-clear request for the IN ring |
| halt_clr_out_i | input | 1 | Halt-clear request for the OUT ring |
| link_chg_i | input | 1 | Port link status change indication |
| cap_en_o | output | 1 | Capability enable |
| doorbell_en_o | output | 1 | Doorbell enable |
| stall_in_o | output | 1 | Answer IN-ring data packets with STALL |
| stall_out_o | output | 1 | Answer OUT-ring data packets with STALL |
| release_o | output | 1 | One-cycle pulse: release the root port and abort ring activity |
| psc_evt_o | output | 1 | Port status change event request |

## Verification
Every registered result is due exactly one clock edge after the stimulus that causes it: a register field after its write, the run flag after a change of cfg_state_i or port_reset_i, and the release and event pulses after the edge that starts them. The live address and burst fields, and doorbell_en_o as a function of the stored bits, change with no delay. Inputs change on the falling edge, and each check samples on the next falling edge, which is exactly one rising edge later. The pulses are sampled once more a cycle later to confirm that they lasted a single cycle.

// File: rtl/dbg_ctl_pkg.sv
// Package: shared field positions and widths for the debug capability
// control register. The bit positions are what software decodes, so they
// are fixed here and are the only place they are written.
package dbg_ctl_pkg;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 7;
    localparam int BURST_W   = 8;
    localparam int EN_BIT    = 31;
    localparam int ADDR_LSB  = 24;
    localparam int BURST_LSB = 16;
    localparam int RSV_LSB   = 5;
    localparam int RSV_MSB   = 15;
    localparam int CHG_BIT   = 4;
    localparam int HIN_BIT   = 3;
    localparam int HOUT_BIT  = 2;
    localparam int LSE_BIT   = 1;
    localparam int RUN_BIT   = 0;
    localparam int N_RING    = 2;

    // Ring index used by the halt generate loop.
    typedef enum logic [0:0] {RING_IN = 1'b0, RING_OUT = 1'b1} ring_e;

    // Register bit holding the halt flag of a ring (IN = 3, OUT = 2).
    function automatic int halt_pos(input int ring);
        return HIN_BIT - ring;
    endfunction
endpackage

// File: rtl/dbg_ctl_run.sv
// Run-state tracker: keeps the run flag, the sticky run-change flag and the
// port-reset lockout.
// Assumes: en_nxt_i is the enable value that will be stored at this edge,
// so that clearing the enable drops run in the same cycle.
module dbg_ctl_run (
    input  logic clk,
    input  logic rst_n,
    input  logic en_nxt_i,
    input  logic cfg_state_i,
    input  logic port_reset_i,
    input  logic chg_clr_i,
    output logic run_q_o,
    output logic run_nxt_o,
    output logic chg_q_o
);
    logic pr_q;
    logic blk_q;
    logic pr_rise;
    logic run_q;
    logic run_nxt;
    logic chg_q;

    // Detect the rising edge of port reset and compute the next run value.
    always_comb begin
        pr_rise = port_reset_i & ~pr_q;
        run_nxt = en_nxt_i & cfg_state_i & ~blk_q & ~pr_rise;
    end

    // Update the run flag, the lockout, the reset history and the sticky change flag (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q  <= 1'b0;
            blk_q <= 1'b0;
            run_q <= 1'b0;
            chg_q <= 1'b0;
        end else begin
            pr_q  <= port_reset_i;
            blk_q <= pr_rise | (blk_q & cfg_state_i);
            run_q <= run_nxt;
            chg_q <= (run_q & ~run_nxt) | (chg_q & ~chg_clr_i);
        end
    end

    assign run_q_o   = run_q;
    assign run_nxt_o = run_nxt;
    assign chg_q_o   = chg_q;
endmodule

// File: rtl/dbg_ctl_halt.sv
// One ring's halt flag. Software sets it by writing 1, and the endpoint
// halt-clear request clears it. It can be set only while running and it is
// forced to 0 when the run flag is low or about to drop.
// Assumes: set_i is already qualified by the write strobe.
module dbg_ctl_halt (
    input  logic clk,
    input  logic rst_n,
    input  logic run_q_i,
    input  logic run_nxt_i,
    input  logic set_i,
    input  logic clr_i,
    output logic halt_o
);
    logic halt_q;

    // Priority: not running, then clear request, then software set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (!run_q_i || !run_nxt_i) begin
            halt_q <= 1'b0;
        end else if (clr_i) begin
            halt_q <= 1'b0;
        end else if (set_i) begin
            halt_q <= 1'b1;
        end
    end

    assign halt_o = halt_q;
endmodule

// File: rtl/dbg_ctl_evt.sv
// Port status change event: a one-cycle request on a rising edge of the link
// status change input while the event enable is set.
// Assumes: link_i is synchronous to clk.
module dbg_ctl_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic lse_i,
    input  logic link_i,
    output logic evt_o
);
    logic link_q;
    logic evt_q;

    // Keep the link history and register the qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            link_q <= link_i;
            evt_q  <= lse_i & link_i & ~link_q;
        end
    end

    assign evt_o = evt_q;
endmodule

// File: rtl/dbg_ctl_reg.sv
// Debug capability control and status register (top). It holds the enable
// and the event enable, produces the release pulse, instantiates the run
// tracker, one halt unit per ring and the event unit, and assembles the
// read word.
// Assumes: writes are whole-word and the read is combinational.
module dbg_ctl_reg
    import dbg_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [REG_W-1:0]   wr_data_i,
    output logic [REG_W-1:0]   rd_data_o,
    input  logic               cfg_state_i,
    input  logic [ADDR_W-1:0]  dev_addr_i,
    input  logic [BURST_W-1:0] max_burst_i,
    input  logic               port_reset_i,
    input  logic               halt_clr_in_i,
    input  logic               halt_clr_out_i,
    input  logic               link_chg_i,
    output logic               cap_en_o,
    output logic               doorbell_en_o,
    output logic               stall_in_o,
    output logic               stall_out_o,
    output logic               release_o,
    output logic               psc_evt_o
);
    logic              en_q;
    logic              en_nxt;
    logic              rel_q;
    logic              lse_q;
    logic              run_q;
    logic              run_nxt;
    logic              chg_q;
    logic [N_RING-1:0] halt;
    logic [N_RING-1:0] halt_clr;

    // Next enable value: the value being written, otherwise held.
    always_comb begin
        en_nxt = wr_en_i ? wr_data_i[EN_BIT] : en_q;
    end

    // Store the enable and the event enable, and form the release pulse on a 1-to-0 change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            rel_q <= 1'b0;
            lse_q <= 1'b0;
        end else begin
            en_q  <= en_nxt;
            rel_q <= en_q & ~en_nxt;
            if (wr_en_i) begin
                lse_q <= wr_data_i[LSE_BIT];
            end
        end
    end

    dbg_ctl_run u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_nxt_i     (en_nxt),
        .cfg_state_i  (cfg_state_i),
        .port_reset_i (port_reset_i),
        .chg_clr_i    (wr_en_i & wr_data_i[CHG_BIT]),
        .run_q_o      (run_q),
        .run_nxt_o    (run_nxt),
        .chg_q_o      (chg_q)
    );

    assign halt_clr[RING_IN]  = halt_clr_in_i;
    assign halt_clr[RING_OUT] = halt_clr_out_i;

    for (genvar g = 0; g < N_RING; g++) begin : g_ring
        dbg_ctl_halt u_halt (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_q_i   (run_q),
            .run_nxt_i (run_nxt),
            .set_i     (wr_en_i & wr_data_i[halt_pos(g)]),
            .clr_i     (halt_clr[g]),
            .halt_o    (halt[g])
        );
    end

    dbg_ctl_evt u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .lse_i  (lse_q),
        .link_i (link_chg_i),
        .evt_o  (psc_evt_o)
    );

    // Assemble the read word; reserved bits stay 0 and the halt bits are gated by run.
    always_comb begin
        rd_data_o = '0;
        rd_data_o[EN_BIT]                   = en_q;
        rd_data_o[ADDR_LSB +: ADDR_W]       = dev_addr_i;
        rd_data_o[BURST_LSB +: BURST_W]     = max_burst_i;
        rd_data_o[CHG_BIT]                  = chg_q;
        rd_data_o[HIN_BIT]                  = halt[RING_IN] & run_q;
        rd_data_o[HOUT_BIT]                 = halt[RING_OUT] & run_q;
        rd_data_o[LSE_BIT]                  = lse_q;
        rd_data_o[RUN_BIT]                  = run_q;
    end

    assign cap_en_o      = en_q;
    assign doorbell_en_o = en_q & ~chg_q;
    assign stall_in_o    = halt[RING_IN];
    assign stall_out_o   = halt[RING_OUT];
    assign release_o     = rel_q;
endmodule

// File: rtl/dbg_ctl_reg_chk.sv
// Checker for dbg_ctl_reg. It looks only at the ports and is attached with
// bind.
module dbg_ctl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] rd_data_o,
    input logic        port_reset_i,
    input logic        link_chg_i,
    input logic        cap_en_o,
    input logic        doorbell_en_o,
    input logic        release_o,
    input logic        psc_evt_o
);
    a_r3_release_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (!cap_en_o && $past(cap_en_o)));

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[15:5] == 11'd0);

    a_r5_run_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_o |-> !rd_data_o[0]);

    a_r6_port_reset_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_reset_i) |=> !rd_data_o[0]);

    a_r7_change_on_run_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data_o[0]) |-> rd_data_o[4]);

    a_r7_doorbell_locked: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[4] |-> !doorbell_en_o);

    a_r8_halt_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[0] |-> (rd_data_o[3:2] == 2'b00));

    a_r12_event_cause: assert property (@(posedge clk) disable iff (!rst_n)
        psc_evt_o |-> ($past(rd_data_o[1]) && $past(link_chg_i)));
endmodule

bind dbg_ctl_reg dbg_ctl_reg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_data_o     (rd_data_o),
    .port_reset_i  (port_reset_i),
    .link_chg_i    (link_chg_i),
    .cap_en_o      (cap_en_o),
    .doorbell_en_o (doorbell_en_o),
    .release_o     (release_o),
    .psc_evt_o     (psc_evt_o)
);

// File: tb/dbg_ctl_reg_tb_top.sv
// Directed bench for dbg_ctl_reg: one task per scenario. Inputs change on the
// falling edge and outputs are sampled on the next falling edge.
module dbg_ctl_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        cfg_state_i = 1'b0;
    logic [6:0]  dev_addr_i = 7'h55;
    logic [7:0]  max_burst_i = 8'h10;
    logic        port_reset_i = 1'b0;
    logic        halt_clr_in_i = 1'b0;
    logic        halt_clr_out_i = 1'b0;
    logic        link_chg_i = 1'b0;
    logic        cap_en_o, doorbell_en_o, stall_in_o, stall_out_o, release_o, psc_evt_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_ctl_reg dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Whole-word write; on return the write edge has passed.
    task automatic wr(input logic [31:0] d);
        wr_en_i = 1'b1;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    function automatic logic [31:0] idf();
        return {1'b0, dev_addr_i, max_burst_i, 16'h0};
    endfunction

    // Enable, leave run-change clear and bring the run flag up.
    task automatic go_run();
        cfg_state_i = 1'b1;
        wr(32'h8000_0010);
        cyc(1);
    endtask

    task automatic t_reset();
        chk("R1 read word", rd_data_o, idf());
        chk("R1 outputs", {26'h0, cap_en_o, doorbell_en_o, stall_in_o, stall_out_o, release_o, psc_evt_o}, 32'h0);
    endtask

    task automatic t_enable_fields();
        wr(32'h8000_FFE0);
        chk("R2 enable read", rd_data_o[31], 32'h1);
        chk("R2 cap_en", cap_en_o, 32'h1);
        chk("R4 fixed fields and reserved", rd_data_o[30:5], {idf()[30:16], 11'h0});
        dev_addr_i = 7'h2A;
        max_burst_i = 8'hC3;
        #1;
        chk("R4 live address/burst", rd_data_o[30:16], {7'h2A, 8'hC3});
        chk("R5 run stays 0 without cfg", rd_data_o[0], 32'h0);
        cfg_state_i = 1'b1;
        cyc(1);
        chk("R5 run rises", rd_data_o[0], 32'h1);
        chk("R7 doorbell enabled", doorbell_en_o, 32'h1);
    endtask

    task automatic t_halt();
        wr(32'h8000_0008);
        chk("R8 IN halt set", rd_data_o[3:2], 32'h2);
        chk("R11 stall_in", {stall_in_o, stall_out_o}, 32'h2);
        wr(32'h8000_0000);
        chk("R8 write 0 no effect", rd_data_o[3:2], 32'h2);
        halt_clr_in_i = 1'b1;
        cyc(1);
        halt_clr_in_i = 1'b0;
        chk("R9 IN halt cleared", rd_data_o[3:2], 32'h0);
        halt_clr_in_i = 1'b1;
        wr(32'h8000_000C);
        halt_clr_in_i = 1'b0;
        chk("R9 clear wins over set", rd_data_o[3:2], 32'h1);
        chk("R11 stall_out", {stall_in_o, stall_out_o}, 32'h1);
        halt_clr_out_i = 1'b1;
        cyc(1);
        halt_clr_out_i = 1'b0;
        chk("R9 OUT halt cleared", rd_data_o[3:2], 32'h0);
    endtask

    task automatic t_drop();
        wr(32'h8000_000C);
        chk("R8 both halts set", rd_data_o[3:2], 32'h3);
        cfg_state_i = 1'b0;
        cyc(1);
        chk("R5 run falls with cfg", rd_data_o[0], 32'h0);
        chk("R7 change flag set", rd_data_o[4], 32'h1);
        chk("R7 doorbell locked", doorbell_en_o, 32'h0);
        chk("R10 halts forced 0", {stall_in_o, stall_out_o}, 32'h0);
        wr(32'h8000_000C);
        chk("R8 writes ignored when not running", {rd_data_o[3:2], stall_in_o, stall_out_o}, 32'h0);
        wr(32'h8000_0010);
        chk("R7 write-1 clears change", rd_data_o[4], 32'h0);
        chk("R7 doorbell reopened", doorbell_en_o, 32'h1);
        cfg_state_i = 1'b1;
        cyc(1);
        chk("R10 halts stay 0 after rerun", {rd_data_o[3:2], rd_data_o[0]}, 32'h1);
    endtask

    task automatic t_set_wins();
        cfg_state_i = 1'b0;
        wr(32'h8000_0010);
        chk("R7 set wins over clear", rd_data_o[4], 32'h1);
        cfg_state_i = 1'b1;
    endtask

    task automatic t_disable();
        go_run();
        chk("R5 running before disable", rd_data_o[0], 32'h1);
        wr(32'h0000_0000);
        chk("R3 release pulse", release_o, 32'h1);
        chk("R5 run cleared with enable", {rd_data_o[31], rd_data_o[4], rd_data_o[0]}, 32'h2);
        cyc(1);
        chk("R3 pulse single cycle", release_o, 32'h0);
        wr(32'h0000_0000);
        chk("R3 no pulse when already 0", release_o, 32'h0);
    endtask

    task automatic t_port_reset();
        go_run();
        chk("R6 running before reset", rd_data_o[0], 32'h1);
        port_reset_i = 1'b1;
        cyc(1);
        port_reset_i = 1'b0;
        chk("R6 run forced 0", {rd_data_o[4], rd_data_o[0]}, 32'h2);
        cyc(3);
        chk("R6 run held 0 while cfg high", rd_data_o[0], 32'h0);
        cfg_state_i = 1'b0;
        cyc(1);
        cfg_state_i = 1'b1;
        cyc(1);
        chk("R6 run returns after cfg cycle", rd_data_o[0], 32'h1);
    endtask

    task automatic t_event();
        wr(32'h8000_0000);
        link_chg_i = 1'b1;
        cyc(1);
        chk("R12 no event when disabled", psc_evt_o, 32'h0);
        cyc(1);
        link_chg_i = 1'b0;
        wr(32'h8000_0002);
        chk("R12 enable reads back", rd_data_o[1], 32'h1);
        link_chg_i = 1'b1;
        cyc(1);
        chk("R12 event on edge", psc_evt_o, 32'h1);
        cyc(1);
        chk("R12 event single cycle", psc_evt_o, 32'h0);
        link_chg_i = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_enable_fields();
        t_halt();
        t_drop();
        t_set_wins();
        t_disable();
        t_port_reset();
        t_event();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule